// File: doc/BRIEF.md
# Indirect Interrupt Router Register File

This block is the register front-end of a 24-pin interrupt router. Software sees only two bus offsets. A select register sits at offset 0x00 and a data window sits at offset 0x10. The value held in the select register decides which internal register the window reaches. That can be the router's identification value, its read-only version word, an arbitration alias of the identification value, or one half of a pin's 64-bit redirection entry. The block owns the redirection table and drives every pin's decoded fields as plain outputs to the delivery logic. It takes remote-pending set and clear pulses back from that logic.

A window write to a redirection entry has side effects beyond storage:
- A write to the low half clears the entry's remote-pending flag.
- A write that flips the mask bit produces a one-cycle mask-change event.
- A write to a level-triggered entry whose request line is high raises a one-cycle service request for that pin.

Reads use plain strobes. Each read returns its data one cycle later, marked by `rd_valid`. There is no back-pressure: the consumer must take the data in the cycle it is valid. Writes complete at the clock edge.

Top module: `irq_router_regfile`

## Requirements
- R1: A write at offset 0x00 stores `bus_wdata[7:0]` as the select value, and a read there returns it zero-extended. Reads at any offset other than 0x00 and 0x10 return zero, and writes there change nothing.
- R2: `rd_valid` is high exactly in the cycle after a `bus_rd` strobe, with `rd_data` valid in that cycle. A read and a write to the same register in one cycle return the value from before the write.
- R3: Select 0x01 reads 0x00170011: pin count minus one in bits 23:16 and version code 0x11 in bits 7:0. Writes to it have no effect.
- R4: Select 0x00 is the identification register. A write keeps `bus_wdata[27:24]`, and a read returns that value in bits 27:24 with all other bits zero. Select 0x02 reads the same value, and writes to select 0x02 are ignored.
- R5: Select 0x10+2n reaches bits 31:0 of pin n's entry and 0x11+2n reaches bits 63:32. The entry layout is vector 7:0, delivery mode 10:8, destination mode 11, remote-pending 14, trigger 15 (1 = level), mask 16, destination 63:56. These fields drive the per-pin outputs.
- R6: A select whose index (select − 0x10, 8-bit wrap, shifted right by one) is 24 or more reads all ones, and a write to it changes nothing. This covers selects 0x03 to 0x0F and 0x40 and above.
- R7: A low-half write forces the entry's remote-pending bit to 0 whatever bit 14 of the data is. A high-half write leaves that bit unchanged.
- R8: `remote_set[n]` sets pin n's remote-pending bit and `remote_clr[n]` clears it. When both are high, set wins. A low-half write to the pin in the same cycle wins over both.
- R9: A low-half write that changes the mask bit pulses `mask_evt_valid` for one cycle after the write edge, with the pin index and the new mask. A write that leaves the mask unchanged raises no event.
- R10: After a write to either half of an entry, `svc_valid` pulses for one cycle carrying the pin index, if the resulting entry is level-triggered and `req_level` of that pin was high in the write cycle. This holds regardless of the mask.
- R11: Reset sets every entry's low half to 0x00010000 (masked) and its high half to 0. It also clears the select value and the identification value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus offset (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Read data |
| req_level | input | 24 | Per-pin request bits from the input stage |
| remote_set | input | 24 | Per-pin remote-pending set pulses |
| remote_clr | input | 24 | Per-pin remote-pending clear pulses |
| pin_vector | output | 192 | Vector of each pin, 8 bits per pin |
| pin_dlv_mode | output | 72 | Delivery mode, 3 bits per pin |
| pin_dest_mode | output | 24 | Destination mode per pin |
| pin_trig_level | output | 24 | Trigger mode per pin (1 = level) |
| pin_mask | output | 24 | Mask bit per pin |
| pin_remote | output | 24 | Remote-pending bit per pin |
| pin_dest | output | 192 | Destination of each pin, 8 bits per pin |
| mask_evt_valid | output | 1 | Mask-change event pulse |
| mask_evt_pin | output | 5 | Pin whose mask changed |
| mask_evt_value | output | 1 | New mask value |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | 5 | Pin to be serviced |

## Verification
Two paths can act on the same remote-pending bit in one cycle. One is a remote-pending set from the delivery logic. The other is a software low-half write to that entry. The bench raises `remote_set` for a pin in the very cycle it writes the pin's low half, and expects the bit to read back as zero, because the write wins. The bench also overlaps a window read with a window write of the same entry, and expects the read to return the value from before the write.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam int ENTRY_W    = 64;
  localparam int BIT_DMODE  = 11;
  localparam int BIT_REMOTE = 14;
  localparam int BIT_TRIG   = 15;
  localparam int BIT_MASK   = 16;
  localparam int DEST_LSB   = 56;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {TGT_NONE, TGT_SEL, TGT_WIN} bus_tgt_e;
  typedef enum logic [2:0] {WR_ID, WR_VER, WR_ARB, WR_ENTRY, WR_BAD} win_reg_e;
endpackage

// File: rtl/irr_decode.sv
module irr_decode
  import irr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       sel,
  output win_reg_e         kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi_half
);
  logic [7:0] off;
  logic [6:0] full_idx;

  assign off      = sel - SEL_TBL;
  assign full_idx = off[7:1];
  assign idx      = full_idx[IDX_W-1:0];
  assign hi_half  = sel[0];

  always_comb begin
    if (sel == SEL_ID)                 kind = WR_ID;
    else if (sel == SEL_VER)           kind = WR_VER;
    else if (sel == SEL_ARB)           kind = WR_ARB;
    else if (int'(full_idx) < NPINS)   kind = WR_ENTRY;
    else                               kind = WR_BAD;
  end
endmodule

// File: rtl/irr_entry_table.sv
module irr_entry_table
  import irr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_hi,
  input  logic [31:0]        wr_data,
  input  logic [NPINS-1:0]   req_level,
  input  logic [NPINS-1:0]   remote_set,
  input  logic [NPINS-1:0]   remote_clr,
  output logic [ENTRY_W-1:0] entry_q [NPINS],
  output logic               mask_evt_valid,
  output logic [IDX_W-1:0]   mask_evt_pin,
  output logic               mask_evt_value,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_pin
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic               hit;
    logic [ENTRY_W-1:0] nxt;

    assign hit = wr_en && (wr_idx == IDX_W'(p));

    always_comb begin
      nxt = entry_q[p];
      if (hit) begin
        if (wr_hi) nxt[63:32] = wr_data;
        else       nxt[31:0]  = wr_data;
      end
      if (remote_clr[p])     nxt[BIT_REMOTE] = 1'b0;
      if (remote_set[p])     nxt[BIT_REMOTE] = 1'b1;
      if (hit && !wr_hi)     nxt[BIT_REMOTE] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) entry_q[p] <= ENTRY_RST;
      else        entry_q[p] <= nxt;
    end

    // R7: a low-half write leaves the remote-pending bit cleared
    assert_low_write_clears_remote_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_hi) |=> !entry_q[p][BIT_REMOTE]);
    // R8: a set pulse without a competing low-half write sets the bit
    assert_remote_set_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_set[p] && !(hit && !wr_hi)) |=> entry_q[p][BIT_REMOTE]);
  end

  logic [ENTRY_W-1:0] old_ent;
  logic               new_trig;

  assign old_ent  = entry_q[wr_idx];
  assign new_trig = wr_hi ? old_ent[BIT_TRIG] : wr_data[BIT_TRIG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_evt_valid <= 1'b0;
      mask_evt_pin   <= '0;
      mask_evt_value <= 1'b0;
      svc_valid      <= 1'b0;
      svc_pin        <= '0;
    end else begin
      mask_evt_valid <= wr_en && !wr_hi && (wr_data[BIT_MASK] != old_ent[BIT_MASK]);
      mask_evt_pin   <= wr_idx;
      mask_evt_value <= wr_data[BIT_MASK];
      svc_valid      <= wr_en && new_trig && req_level[wr_idx];
      svc_pin        <= wr_idx;
    end
  end

  // R9: the event reports the mask now held in the table
  assert_mask_evt_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> (entry_q[mask_evt_pin][BIT_MASK] == mask_evt_value));
  // R10: a service request only names a level-triggered entry
  assert_svc_level_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> entry_q[svc_pin][BIT_TRIG]);
endmodule

// File: rtl/irr_readback.sv
module irr_readback
  import irr_pkg::*;
#(
  parameter int          NPINS    = 24,
  parameter int          IDX_W    = 5,
  parameter logic [7:0]  VER_CODE = 8'h11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  bus_tgt_e           tgt,
  input  win_reg_e           kind,
  input  logic [IDX_W-1:0]   idx,
  input  logic               hi_half,
  input  logic [7:0]         sel,
  input  logic [3:0]         id,
  input  logic [ENTRY_W-1:0] entries [NPINS],
  output logic               rd_valid,
  output logic [31:0]        rd_data
);
  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  logic [31:0]        val;
  logic [ENTRY_W-1:0] ent;

  assign ent = entries[idx];

  always_comb begin
    val = '0;
    unique case (tgt)
      TGT_SEL: val = {24'h0, sel};
      TGT_WIN: begin
        unique case (kind)
          WR_ID, WR_ARB: val = {4'h0, id, 24'h0};
          WR_VER:        val = {8'h00, MAX_PIN, 8'h00, VER_CODE};
          WR_ENTRY:      val = hi_half ? ent[63:32] : ent[31:0];
          default:       val = '1;
        endcase
      end
      default: val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= val;
    end
  end

  assert_rd_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_oob_reads_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && tgt == TGT_WIN && kind == WR_BAD) |=> (rd_data == 32'hFFFF_FFFF));
  assert_other_offset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && tgt == TGT_NONE) |=> (rd_data == 32'h0));
endmodule

// File: rtl/irq_router_regfile.sv
module irq_router_regfile
  import irr_pkg::*;
#(
  parameter int          NPINS    = 24,
  parameter logic [7:0]  VER_CODE = 8'h11,
  localparam int         IDX_W    = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  input  logic [NPINS-1:0]   req_level,
  input  logic [NPINS-1:0]   remote_set,
  input  logic [NPINS-1:0]   remote_clr,
  output logic [NPINS*8-1:0] pin_vector,
  output logic [NPINS*3-1:0] pin_dlv_mode,
  output logic [NPINS-1:0]   pin_dest_mode,
  output logic [NPINS-1:0]   pin_trig_level,
  output logic [NPINS-1:0]   pin_mask,
  output logic [NPINS-1:0]   pin_remote,
  output logic [NPINS*8-1:0] pin_dest,
  output logic               mask_evt_valid,
  output logic [IDX_W-1:0]   mask_evt_pin,
  output logic               mask_evt_value,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_pin
);
  bus_tgt_e           tgt;
  win_reg_e           kind;
  logic [IDX_W-1:0]   idx;
  logic               hi_half;
  logic [7:0]         sel_q;
  logic [3:0]         id_q;
  logic               tbl_wr;
  logic [ENTRY_W-1:0] ent [NPINS];

  always_comb begin
    if (bus_addr == OFF_SEL)      tgt = TGT_SEL;
    else if (bus_addr == OFF_WIN) tgt = TGT_WIN;
    else                          tgt = TGT_NONE;
  end

  irr_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_decode (
    .sel(sel_q), .kind(kind), .idx(idx), .hi_half(hi_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (bus_wr) begin
      if (tgt == TGT_SEL) sel_q <= bus_wdata[7:0];
      if (tgt == TGT_WIN && kind == WR_ID) id_q <= bus_wdata[27:24];
    end
  end

  assign tbl_wr = bus_wr && (tgt == TGT_WIN) && (kind == WR_ENTRY);

  irr_entry_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(idx), .wr_hi(hi_half), .wr_data(bus_wdata),
    .req_level(req_level), .remote_set(remote_set), .remote_clr(remote_clr),
    .entry_q(ent),
    .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
    .mask_evt_value(mask_evt_value),
    .svc_valid(svc_valid), .svc_pin(svc_pin)
  );

  irr_readback #(.NPINS(NPINS), .IDX_W(IDX_W), .VER_CODE(VER_CODE)) u_readback (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .tgt(tgt), .kind(kind),
    .idx(idx), .hi_half(hi_half), .sel(sel_q), .id(id_q), .entries(ent),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_out
    assign pin_vector[p*8 +: 8]   = ent[p][7:0];
    assign pin_dlv_mode[p*3 +: 3] = ent[p][10:8];
    assign pin_dest_mode[p]       = ent[p][BIT_DMODE];
    assign pin_trig_level[p]      = ent[p][BIT_TRIG];
    assign pin_mask[p]            = ent[p][BIT_MASK];
    assign pin_remote[p]          = ent[p][BIT_REMOTE];
    assign pin_dest[p*8 +: 8]     = ent[p][DEST_LSB +: 8];
  end

  // R1: writes outside the two offsets leave the select value alone
  assert_sel_untouched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && tgt == TGT_NONE) |=> $stable(sel_q));
  // R4: writes through the arbitration alias do not change the identification value
  assert_arb_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && tgt == TGT_WIN && kind == WR_ARB) |=> $stable(id_q));
endmodule

// File: tb/irq_router_regfile_test.sv
`timescale 1ns/1ps
module irq_router_regfile_test;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] req_level = '0;
  logic [NP-1:0] remote_set = '0;
  logic [NP-1:0] remote_clr = '0;
  logic [NP*8-1:0] pin_vector, pin_dest;
  logic [NP*3-1:0] pin_dlv_mode;
  logic [NP-1:0] pin_dest_mode, pin_trig_level, pin_mask, pin_remote;
  logic          mask_evt_valid, mask_evt_value, svc_valid;
  logic [4:0]    mask_evt_pin, svc_pin;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_router_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .req_level(req_level), .remote_set(remote_set), .remote_clr(remote_clr),
    .pin_vector(pin_vector), .pin_dlv_mode(pin_dlv_mode), .pin_dest_mode(pin_dest_mode),
    .pin_trig_level(pin_trig_level), .pin_mask(pin_mask), .pin_remote(pin_remote),
    .pin_dest(pin_dest), .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
    .mask_evt_value(mask_evt_value), .svc_valid(svc_valid), .svc_pin(svc_pin)
  );

  typedef struct packed {
    logic [7:0]  sel;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h01, 1'b0, 32'h0,         32'h0017_0011},  // R3 version
    '{8'h01, 1'b1, 32'hFFFF_FFFF, 32'h0017_0011},  // R3 write ignored
    '{8'h00, 1'b1, 32'hA500_0000, 32'h0500_0000},  // R4 id keeps 27:24
    '{8'h02, 1'b1, 32'h0F00_0000, 32'h0500_0000},  // R4 arbitration alias
    '{8'h12, 1'b1, 32'h0000_C0AB, 32'h0000_80AB},  // R7 bit 14 dropped
    '{8'h13, 1'b1, 32'h7F00_FFFF, 32'h7F00_FFFF},  // R5 high half
    '{8'h41, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF},  // R6 index 24
    '{8'h0F, 1'b0, 32'h0,         32'hFFFF_FFFF},  // R6 select below table
    '{8'h40, 1'b0, 32'h0,         32'hFFFF_FFFF},  // R6 index 24 low
    '{8'h3F, 1'b1, 32'hC300_0000, 32'hC300_0000}   // R5 last pin high half
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_valid ? rd_data : 32'hDEAD_BEEF;
  endtask

  task automatic pulse_remote(input logic [NP-1:0] s, input logic [NP-1:0] c);
    @(negedge clk);
    remote_set = s; remote_clr = c;
    @(negedge clk);
    remote_set = '0; remote_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mask", {8'h0, pin_mask}, 32'h00FF_FFFF);
    chk("R11 remote", {8'h0, pin_remote}, 32'h0);
    chk("R2 idle valid", {31'h0, rd_valid}, 32'h0);
    bus_read(8'h00, d); chk("R11 select", d, 32'h0);
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h10, d); chk("R11 id", d, 32'h0);
    bus_write(8'h00, 32'h0000_001A);
    bus_read(8'h10, d); chk("R11 entry low", d, 32'h0001_0000);
    bus_write(8'h00, 32'h0000_001B);
    bus_read(8'h10, d); chk("R11 entry high", d, 32'h0);

    // table walk
    foreach (VECS[i]) begin
      bus_write(8'h00, {24'h0, VECS[i].sel});
      if (VECS[i].wr) bus_write(8'h10, VECS[i].wdata);
      bus_read(8'h10, d);
      chk($sformatf("vec%0d", i), d, VECS[i].exp);
    end
    chk("R5 vector pin1", {24'h0, pin_vector[15:8]}, 32'hAB);
    chk("R5 trig pin1", {31'h0, pin_trig_level[1]}, 32'h1);
    chk("R5 dest pin1", {24'h0, pin_dest[15:8]}, 32'h7F);
    chk("R5 dest pin23", {24'h0, pin_dest[191:184]}, 32'hC3);

    // R1 other offsets
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, d); chk("R1 other offset", d, 32'h0);
    bus_read(8'h00, d); chk("R1 select kept", d, 32'h3F);

    // R2 read and write of one register in the same cycle
    bus_write(8'h00, 32'h0000_003E);
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h0000_0077; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R2 valid", {31'h0, rd_valid}, 32'h1);
    chk("R2 old value", rd_data, 32'h0001_0000);
    @(negedge clk);
    chk("R2 valid drops", {31'h0, rd_valid}, 32'h0);
    bus_read(8'h10, d); chk("R2 new value", d, 32'h0000_0077);

    // R9 mask-change events
    bus_write(8'h00, 32'h0000_0016);
    bus_write(8'h10, 32'h0000_0020);
    chk("R9 evt", {31'h0, mask_evt_valid}, 32'h1);
    chk("R9 pin", {27'h0, mask_evt_pin}, 32'h3);
    chk("R9 value", {31'h0, mask_evt_value}, 32'h0);
    @(negedge clk);
    chk("R9 one cycle", {31'h0, mask_evt_valid}, 32'h0);
    bus_write(8'h10, 32'h0000_0021);
    chk("R9 no change", {31'h0, mask_evt_valid}, 32'h0);
    bus_write(8'h10, 32'h0001_0021);
    chk("R9 remask", {30'h0, mask_evt_valid, mask_evt_value}, 32'h3);

    // R10 service requests
    req_level = 24'h00_0030;
    bus_write(8'h00, 32'h0000_0018);
    bus_write(8'h10, 32'h0001_8030);
    chk("R10 svc", {31'h0, svc_valid}, 32'h1);
    chk("R10 pin", {27'h0, svc_pin}, 32'h4);
    bus_write(8'h00, 32'h0000_001A);
    bus_write(8'h10, 32'h0000_0031);
    chk("R10 edge no svc", {31'h0, svc_valid}, 32'h0);
    bus_write(8'h00, 32'h0000_0019);
    bus_write(8'h10, 32'h0100_0000);
    chk("R10 high half svc", {27'h0, svc_valid, svc_pin[3:0]}, 32'h14);
    req_level = '0;

    // R8 remote-pending from delivery logic
    pulse_remote(24'h10, 24'h0);
    chk("R8 set", {31'h0, pin_remote[4]}, 32'h1);
    bus_write(8'h00, 32'h0000_0018);
    bus_read(8'h10, d); chk("R8 readback", d, 32'h0001_C030);
    pulse_remote(24'h10, 24'h10);
    chk("R8 set wins", {31'h0, pin_remote[4]}, 32'h1);
    pulse_remote(24'h0, 24'h10);
    chk("R8 clear", {31'h0, pin_remote[4]}, 32'h0);
    pulse_remote(24'h10, 24'h0);
    bus_write(8'h00, 32'h0000_0019);
    bus_write(8'h10, 32'h0200_0000);
    chk("R7 high keeps remote", {31'h0, pin_remote[4]}, 32'h1);
    // R8 low-half write and set in one cycle: write wins
    bus_write(8'h00, 32'h0000_0018);
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h0001_C030; bus_wr = 1'b1; remote_set = 24'h10;
    @(negedge clk);
    bus_wr = 1'b0; remote_set = '0;
    chk("R8 write beats set", {31'h0, pin_remote[4]}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule